// File: doc/BRIEF.md
# Interactive Convergence Clock Corrector

This block is the clock-resynchronization unit of one node in a cluster of `NODES` nodes, of which up to `FAULTS` may be faulty. The node keeps a local time counter that advances by one every clock cycle. Every `PERIOD_CYC` cycles it runs a resynchronization round.

Each round opens with `NODES` listening windows of `WIN_CYC` cycles each, one window per node. Window `w` belongs to node `w`. Only a message from that node is accepted during its window. For each accepted message the unit computes a signed skew: the received timestamp minus the local time at the receive instant. A skew whose magnitude exceeds `THRESH` is forced to zero. A peer that stays silent contributes zero, and so does the node's own slot.

After the last window, a settling interval of `SETTLE_CYC` cycles follows. During it the unit sums all `NODES` skews and divides the sum by `NODES`, rounding toward zero. A power-of-two node count uses a shift. Any other count uses a bit-serial divider. At the last cycle of the interval the quotient is added to the local time, and a done strobe pulses.

Top module: `icc_corrector`

## Requirements
- R1: While `rst_n` is low, `local_time` is 0 and `corr_done` is 0.
- R2: Except at the correction cycle, `local_time` increases by exactly one per clock, wrapping modulo 2^`TW`.
- R3: A message is accepted only when `rx_src` equals the index of the current window and that index is not `SELF_ID`, and only the first such message in that window counts. Messages whose `rx_src` names another window, this node, or no node, and messages sent after the windows have ended, have no effect on the correction.
- R4: An accepted message yields skew = `rx_stamp` − `local_time`, sampled at the same clock edge and taken as a signed `TW`-bit value.
- R5: A skew whose magnitude is greater than `THRESH` counts as zero. A magnitude equal to `THRESH` is kept.
- R6: The node's own slot, and any peer with no accepted message in its window, contribute zero to the sum. The divisor is always `NODES`.
- R7: The correction is the sum of the `NODES` skews divided by `NODES`, truncated toward zero for both signs.
- R8: Round cycle 0 is the first edge after reset release, and a round spans `PERIOD_CYC` cycles. At round cycle `NODES*WIN_CYC+SETTLE_CYC-1`, `local_time` becomes its old value + 1 + correction. `corr_done` is 1 during exactly the next cycle and 0 at every other time. The parameters must satisfy `NODES > 3*FAULTS`, `NODES*WIN_CYC+SETTLE_CYC < PERIOD_CYC`, and `SETTLE_CYC` no shorter than the divider latency.
- R9: Skews captured in one round do not carry into the next. A round with no accepted message applies a correction of zero and still pulses `corr_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A broadcast timestamp is present this cycle |
| rx_src | input | IDW | Index of the sending node |
| rx_stamp | input | TW | Sender's clock value |
| local_time | output | TW | Corrected local time |
| corr_done | output | 1 | One-cycle pulse after a correction is applied |

## Verification
The hardest case to reach from the ports is a round whose accepted skew set is deliberately polluted. Such a round mixes a second message in an already-filled window, a message one cycle past a window's end, one from this node, one naming a nonexistent node, and late traffic during the settling interval. All of these must leave the correction untouched. The stimulus computes every timestamp from the reference model's own view of local time, so each intended skew, including ones exactly at and one past `THRESH`, arrives exactly. Other rounds drive negative sums that do not divide evenly, and a fully silent round.

// File: rtl/icc_corrector.sv
module icc_corrector #(
  parameter int NODES      = 5,
  parameter int FAULTS     = 1,
  parameter int TW         = 32,
  parameter int WIN_CYC    = 16,
  parameter int SETTLE_CYC = 48,
  parameter int PERIOD_CYC = 200,
  parameter int SELF_ID    = 2,
  parameter int THRESH     = 40,
  parameter int IDW        = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_valid,
  input  logic [IDW-1:0] rx_src,
  input  logic [TW-1:0]  rx_stamp,
  output logic [TW-1:0]  local_time,
  output logic           corr_done
);
  localparam int SUMW     = TW + $clog2(NODES) + 1;
  localparam int WINS_END = NODES * WIN_CYC;
  localparam int APPLY_AT = WINS_END + SETTLE_CYC - 1;
  localparam int PCW      = $clog2(PERIOD_CYC);
  localparam int WCW      = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam bit POW2     = (NODES & (NODES - 1)) == 0;
  localparam int SH       = $clog2(NODES);
  localparam int DIV_LAT  = POW2 ? 1 : SUMW + 1;

  initial begin
    p_cfg_r8: assert (NODES > 3 * FAULTS && WINS_END + SETTLE_CYC < PERIOD_CYC
                      && SETTLE_CYC >= DIV_LAT + 1 && SELF_ID < NODES)
      else $error("icc_corrector: parameter set breaks the round schedule");
  end

  logic [PCW-1:0] pc;
  logic [IDW-1:0] win;
  logic [WCW-1:0] wcnt;
  logic           in_wins, apply, load;

  assign in_wins = pc < PCW'(WINS_END);
  assign apply   = pc == PCW'(APPLY_AT);
  assign load    = pc == PCW'(WINS_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc   <= '0;
      win  <= '0;
      wcnt <= '0;
    end else if (pc == PCW'(PERIOD_CYC - 1)) begin
      pc   <= '0;
      win  <= '0;
      wcnt <= '0;
    end else begin
      pc <= pc + 1'b1;
      if (in_wins) begin
        if (wcnt == WCW'(WIN_CYC - 1)) begin
          wcnt <= '0;
          win  <= win + 1'b1;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
    end
  end

  logic signed [TW-1:0] raw;
  logic [TW-1:0]        raw_mag;
  logic                 take;

  assign raw     = signed'(rx_stamp - local_time);
  assign raw_mag = raw[TW-1] ? TW'(-raw) : TW'(raw);
  assign take    = rx_valid && in_wins && rx_src == win && win != IDW'(SELF_ID);

  logic signed [TW-1:0] skew [NODES];
  logic [NODES-1:0]     heard;

  for (genvar i = 0; i < NODES; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        skew[i]  <= '0;
        heard[i] <= 1'b0;
      end else if (apply) begin
        skew[i]  <= '0;
        heard[i] <= 1'b0;
      end else if (take && win == IDW'(i) && !heard[i]) begin
        skew[i]  <= (raw_mag > TW'(THRESH)) ? '0 : raw;
        heard[i] <= 1'b1;
      end
    end

    p_skew_band_r5: assert property (@(posedge clk) disable iff (!rst_n)
      skew[i] <= THRESH && skew[i] >= -THRESH);
  end

  p_own_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    skew[SELF_ID] == '0);

  logic signed [SUMW-1:0] sum_c;
  always_comb begin
    sum_c = '0;
    for (int i = 0; i < NODES; i++) sum_c = sum_c + SUMW'(skew[i]);
  end

  logic [SUMW-1:0] sum_mag, dq;
  logic            dneg, busy;
  assign sum_mag = sum_c[SUMW-1] ? SUMW'(-sum_c) : SUMW'(sum_c);

  if (POW2) begin : g_shift
    assign busy = 1'b0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dq   <= '0;
        dneg <= 1'b0;
      end else if (load) begin
        dq   <= sum_mag >> SH;
        dneg <= sum_c[SUMW-1];
      end
    end
  end else begin : g_serial
    localparam int CW = $clog2(SUMW + 1);
    logic [SUMW-1:0] dr, r_sh;
    logic [CW-1:0]   dcnt;
    logic            run;
    assign r_sh = {dr[SUMW-2:0], dq[SUMW-1]};
    assign busy = run;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dq   <= '0;
        dr   <= '0;
        dcnt <= '0;
        run  <= 1'b0;
        dneg <= 1'b0;
      end else if (load) begin
        dq   <= sum_mag;
        dr   <= '0;
        dcnt <= CW'(SUMW);
        run  <= 1'b1;
        dneg <= sum_c[SUMW-1];
      end else if (run) begin
        if (r_sh >= SUMW'(NODES)) begin
          dr <= r_sh - SUMW'(NODES);
          dq <= {dq[SUMW-2:0], 1'b1};
        end else begin
          dr <= r_sh;
          dq <= {dq[SUMW-2:0], 1'b0};
        end
        dcnt <= dcnt - 1'b1;
        if (dcnt == CW'(1)) run <= 1'b0;
      end
    end
  end

  logic [TW-1:0] corr;
  assign corr = dneg ? TW'(-dq) : TW'(dq);

  p_div_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    apply |-> !busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      local_time <= '0;
      corr_done  <= 1'b0;
    end else begin
      local_time <= local_time + TW'(1) + (apply ? corr : '0);
      corr_done  <= apply;
    end
  end

  p_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> local_time == $past(local_time) + TW'(1));
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    corr_done |=> !corr_done);
  p_pulse_place_r8: assert property (@(posedge clk) disable iff (!rst_n)
    corr_done |-> pc == PCW'(APPLY_AT + 1));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> heard == '0);
endmodule

// File: tb/sim_icc_corrector.sv
module sim_icc_corrector;
  localparam int N = 5, W = 16, K = 48, P = 200, SELF = 2, TH = 40;
  localparam int APPLY = N * W + K - 1;
  localparam int ROUNDS = 6;

  logic        clk = 0, rst_n = 0, rx_valid = 0;
  logic [2:0]  rx_src = '0;
  logic [31:0] rx_stamp = '0;
  logic [31:0] local_time;
  logic        corr_done;

  icc_corrector u0 (.clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_src(rx_src),
                    .rx_stamp(rx_stamp), .local_time(local_time), .corr_done(corr_done));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] m_time = '0;
  int  m_pc = 0, round = 0;
  bit  m_done = 0;
  int  m_skew [N];
  bit  m_heard [N];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_time = '0; m_pc = 0; m_done = 0;
      for (int i = 0; i < N; i++) begin m_skew[i] = 0; m_heard[i] = 0; end
    end else begin
      if (m_pc < N * W) begin
        int w, d;
        w = m_pc / W;
        if (rx_valid && int'(rx_src) == w && w != SELF && !m_heard[w]) begin
          d = $signed(rx_stamp - m_time);
          if (d > TH || d < -TH) d = 0;
          m_skew[w] = d; m_heard[w] = 1;
        end
      end
      if (m_pc == APPLY) begin
        longint s, q;
        s = 0;
        for (int i = 0; i < N; i++) s += m_skew[i];
        q = s / N;
        m_time = m_time + 32'd1 + 32'(q);
        m_done = 1;
        for (int i = 0; i < N; i++) begin m_skew[i] = 0; m_heard[i] = 0; end
      end else begin
        m_time = m_time + 32'd1;
        m_done = 0;
      end
      if (m_pc == P - 1) begin m_pc = 0; round++; end else m_pc++;
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(int src, int sk);
    rx_valid = 1; rx_src = 3'(src); rx_stamp = m_time + 32'(sk);
  endtask

  task automatic drive(int r, int pc);
    rx_valid = 0;
    case (r)
      0: case (pc) 3: put(0, 7); 20: put(1, -3); 50: put(3, 10); 79: put(4, 4); default: ; endcase
      1: case (pc) 0: put(0, -7); 31: put(1, -3); 48: put(3, -10); 70: put(4, -4); default: ; endcase
      2: case (pc) 5: put(0, 41); 17: put(1, 40); 60: put(3, -41); default: ; endcase
      3: case (pc)
           2: put(3, 30); 6: put(0, 10); 7: put(6, 9); 16: put(0, 25); 18: put(1, 5);
           19: put(1, 20); 40: put(2, 35); 55: put(3, -5); 100: put(0, 33); default: ;
         endcase
      5: case (pc) 10: put(4, 15); 35: put(2, 20); 100: put(1, 9); default: ; endcase
      default: ;
    endcase
  endtask

  int exp_corr [ROUNDS] = '{3, -4, 8, 2, 0, 0};
  string round_req [ROUNDS] = '{"R4 R7 pos", "R7 neg", "R5 R6", "R3", "R9", "R3 R6"};

  initial begin
    logic [31:0] t_before;
    t_before = '0;
    repeat (3) @(negedge clk);
    check(local_time == 0, "R1 time", local_time, 0);
    check(corr_done == 0, "R1 done", corr_done, 0);
    rst_n = 1;
    drive(0, 0);
    while (round < ROUNDS) begin
      @(negedge clk);
      check(local_time == m_time, "R2 time track", local_time, m_time);
      check(corr_done == m_done, "R8 done strobe", corr_done, m_done);
      if (m_done)
        check(local_time == t_before + 32'd1 + 32'(exp_corr[round]), round_req[round],
              $signed(local_time - t_before - 32'd1), exp_corr[round]);
      if (m_pc == APPLY) t_before = local_time;
      if (round < ROUNDS) drive(round, m_pc);
    end
    rx_valid = 0;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule